// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block runs the external bus cycles that serve accesses which fall outside internal memory. On one port it sends the low address byte and carries the data. A second port holds the high address byte for the whole cycle. The block drives an address latch enable pulse that lets an outside latch capture the low byte. It drives a low-active program-store enable for code fetches, and low-active read and write strobes for data accesses.

Each edge of every strobe sits at a fixed count of oscillator clocks from the start of the cycle. The requester offers a kind, an address and write data on `req_i` while `busy_o` is low. The block accepts the request on that clock edge. It reports completion with a one-clock `done_o`, and returns fetched or read bytes on `rdata_o`.

In the requirements below, clock c0 is the first clock after the edge that accepted a request. The kind code on `kind_i` is 0 for fetch, 1 for read and 2 for write. Code 3 is run as a read.

Top module: `xbus_cycle_gen`

## Requirements
- R1: After reset, `ale_o`=0, `psen_no`=`rd_no`=`wr_no`=1, `ad_oe_o`=0, `busy_o`=0 and `done_o`=0.
- R2: `ale_o` is high in c0 and c1 only. `ahi_o` carries address bits 15:8 for the whole cycle. When `ad_oe_o` is high in c0..c2, `ad_o` carries address bits 7:0.
- R3: A fetch (kind 0) drives `psen_no` low in c2+1..c5, that is c3, c4 and c5, and in no other clock. `rd_no` and `wr_no` stay high.
- R4: A read (kind 1, or kind 3) drives `rd_no` low in c5..c10 only, which is six clocks. `psen_no` and `wr_no` stay high.
- R5: A write (kind 2) drives `wr_no` low in c5..c10 only. At most one of `psen_no`, `rd_no` and `wr_no` is low at any time.
- R6: A write drives `ad_oe_o` high in c0..c11. `ad_o` shows the write data from c4 through c11, which is one clock before the strobe falls to one clock after it rises.
- R7: `ad_oe_o` is low from c3 in a fetch, from c5 in a read, and while idle.
- R8: `rdata_o` takes `ad_i` as sampled in the last low clock of the strobe (c5 for a fetch, c10 for a read). It shows that value from the final clock of the cycle and holds it until the next capture.
- R9: `done_o` is a single-clock pulse in the final clock of a cycle: c6 for a fetch, c11 for a read or a write.
- R10: `busy_o` is high from c0 up to, but not including, the final clock. A request made while `busy_o` is high is ignored and does not change the cycle in progress.
- R11: A request held high in the final clock is accepted there. Its `ale_o` rises in the next clock, one clock after the strobe returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a bus cycle |
| kind_i | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write, 3 read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Cycle in progress, requests ignored |
| done_o | output | 1 | Final clock of a cycle |
| rdata_o | output | 8 | Captured fetch or read byte |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program-store enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Multiplexed low address / write data out |
| ad_oe_o | output | 1 | Drive enable for the multiplexed port |
| ad_i | input | 8 | Multiplexed port read-back |
| ahi_o | output | 8 | High address byte |

## Verification
Every output is decoded from the registered phase counter. Each result is therefore due in a known clock cN, counted from the edge that accepted the request. The bench raises the request half a clock before that edge, so the next falling edge falls inside c0. It then compares every strobe, the port drive and the status outputs against the expected table at each later falling edge, through to the final clock.

The bench drives `ad_i` with the wanted byte only during the last low clock of the strobe, and with its complement elsewhere. A capture one clock early or late therefore shows on `rdata_o` in the final clock. Ignored and chained requests are placed at chosen clocks inside a running cycle, and the next cycle's c0 is checked for position.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ALE_W  = 2,
  parameter int GAP_F  = 1,
  parameter int PSEN_W = 3,
  parameter int GAP_D  = 3,
  parameter int STB_W  = 6,
  parameter int PW     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           kind_i,
  output logic                 active_o,
  output logic [PW-1:0]        phase_o,
  output xbus_pkg::kind_e      kind_o,
  output logic                 last_o,
  output logic                 accept_o,
  output logic                 busy_o
);
  import xbus_pkg::*;

  localparam logic [PW-1:0] F_LAST = PW'(ALE_W + GAP_F + PSEN_W);
  localparam logic [PW-1:0] D_LAST = PW'(ALE_W + GAP_D + STB_W);

  logic            active_q;
  logic [PW-1:0]   phase_q;
  kind_e           kind_q;
  kind_e           kind_in;

  assign kind_in  = (kind_i == 2'd3) ? KIND_READ : kind_e'(kind_i);
  assign last_o   = active_q && (phase_q == ((kind_q == KIND_FETCH) ? F_LAST : D_LAST));
  assign accept_o = req_i && (!active_q || last_o);
  assign busy_o   = active_q && !last_o;
  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign kind_o   = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      kind_q   <= KIND_FETCH;
    end else if (accept_o) begin
      active_q <= 1'b1;
      phase_q  <= '0;
      kind_q   <= kind_in;
    end else if (last_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      phase_q  <= phase_q + 1'b1;
    end
  end

  AST_BUSY_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> active_q && (phase_q == $past(phase_q) + 1'b1) && (kind_q == $past(kind_q))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o); // R9
  AST_CHAIN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && req_i) |=> active_q && (phase_q == '0)); // R11
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe #(
  parameter int ALE_W  = 2,
  parameter int GAP_F  = 1,
  parameter int PSEN_W = 3,
  parameter int GAP_D  = 3,
  parameter int STB_W  = 6,
  parameter int PW     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic [PW-1:0]        phase_i,
  input  xbus_pkg::kind_e      kind_i,
  output logic                 ale_o,
  output logic                 psen_no,
  output logic                 rd_no,
  output logic                 wr_no,
  output logic                 oe_o,
  output logic                 wsel_o,
  output logic                 cap_o
);
  import xbus_pkg::*;

  localparam logic [PW-1:0] P_ALE  = PW'(ALE_W);
  localparam logic [PW-1:0] P_PSON = PW'(ALE_W + GAP_F);
  localparam logic [PW-1:0] P_PSOF = PW'(ALE_W + GAP_F + PSEN_W);
  localparam logic [PW-1:0] P_STON = PW'(ALE_W + GAP_D);
  localparam logic [PW-1:0] P_STOF = PW'(ALE_W + GAP_D + STB_W);
  localparam logic [PW-1:0] P_WDON = PW'(ALE_W + GAP_D - 1);
  localparam int CW = $clog2(STB_W + 2);

  logic is_f, is_r, is_w, in_ps, in_st;

  assign is_f  = active_i && (kind_i == KIND_FETCH);
  assign is_r  = active_i && (kind_i == KIND_READ);
  assign is_w  = active_i && (kind_i == KIND_WRITE);
  assign in_ps = (phase_i >= P_PSON) && (phase_i < P_PSOF);
  assign in_st = (phase_i >= P_STON) && (phase_i < P_STOF);

  assign ale_o   = active_i && (phase_i < P_ALE);
  assign psen_no = !(is_f && in_ps);
  assign rd_no   = !(is_r && in_st);
  assign wr_no   = !(is_w && in_st);
  assign wsel_o  = is_w && (phase_i >= P_WDON);
  assign oe_o    = is_w || (is_f && phase_i < P_PSON) || (is_r && phase_i < P_STON);
  assign cap_o   = (is_f && phase_i == P_PSOF - 1'b1) || (is_r && phase_i == P_STOF - 1'b1);

  // length of the current data-strobe low run, for the width check
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_cnt <= '0;
    else if (!rd_no || !wr_no)  low_cnt <= low_cnt + 1'b1;
    else                        low_cnt <= '0;
  end

  AST_STB_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_no) || $rose(wr_no)) |-> (low_cnt == CW'(STB_W))); // R4
  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~psen_no, ~rd_no, ~wr_no, ale_o})); // R5
  AST_PORT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(psen_no) || $fell(rd_no)) |-> !oe_o); // R7
  AST_WDATA_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (oe_o && wsel_o)); // R6
endmodule

// File: rtl/xbus_port.sv
module xbus_port #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wsel_i,
  input  logic            cap_i,
  input  logic [DW-1:0]   ad_i,
  output logic [DW-1:0]   ad_o,
  output logic [AW-DW-1:0] ahi_o,
  output logic [DW-1:0]   rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (cap_i) rdata_q <= ad_i;
  end

  assign ad_o    = wsel_i ? wdata_q : addr_q[DW-1:0];
  assign ahi_o   = addr_q[AW-1:DW];
  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rdata_q)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_q)); // R2
endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ALE_W  = 2,
  parameter int GAP_F  = 1,
  parameter int PSEN_W = 3,
  parameter int GAP_D  = 3,
  parameter int STB_W  = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o,
  output logic            ale_o,
  output logic            psen_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  input  logic [DW-1:0]   ad_i,
  output logic [AW-DW-1:0] ahi_o
);
  localparam int PW = $clog2(ALE_W + GAP_D + STB_W + 2);

  logic            active, last, accept, wsel, cap;
  logic [PW-1:0]   phase;
  xbus_pkg::kind_e kind;

  xbus_seq #(.ALE_W(ALE_W), .GAP_F(GAP_F), .PSEN_W(PSEN_W), .GAP_D(GAP_D),
             .STB_W(STB_W), .PW(PW)) u_seq (
    .clk_i, .rst_ni, .req_i, .kind_i,
    .active_o(active), .phase_o(phase), .kind_o(kind),
    .last_o(last), .accept_o(accept), .busy_o(busy_o)
  );

  xbus_strobe #(.ALE_W(ALE_W), .GAP_F(GAP_F), .PSEN_W(PSEN_W), .GAP_D(GAP_D),
                .STB_W(STB_W), .PW(PW)) u_stb (
    .clk_i, .rst_ni, .active_i(active), .phase_i(phase), .kind_i(kind),
    .ale_o, .psen_no, .rd_no, .wr_no, .oe_o(ad_oe_o), .wsel_o(wsel), .cap_o(cap)
  );

  xbus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i, .rst_ni, .accept_i(accept), .addr_i, .wdata_i,
    .wsel_i(wsel), .cap_i(cap), .ad_i, .ad_o, .ahi_o, .rdata_o
  );

  assign done_o = last;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !done_o |-> !ad_oe_o && psen_no && rd_no && wr_no
                         || ($past(done_o) && ale_o)); // R1
endmodule

// File: tb/sim_xbus_cycle_gen.sv
module sim_xbus_cycle_gen;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, ad_in = '0;
  logic busy, done, ale, psen_n, rd_n, wr_n, oe;
  logic [7:0] rdata, ad_out, ahi;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xbus_cycle_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata), .ale_o(ale),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .ad_o(ad_out), .ad_oe_o(oe),
    .ad_i(ad_in), .ahi_o(ahi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // present a request so that the next falling edge lies in c0
  task automatic launch(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; kind = k; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  // called at the falling edge inside c0; walks the whole cycle
  task automatic run_body(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                          input logic [7:0] rin, input bit ign, input bit hold,
                          input logic [1:0] nk, input logic [15:0] na, input logic [7:0] nd);
    bit isf = (k == 2'd0);
    bit isw = (k == 2'd2);
    bit isr = !isf && !isw;
    int last = isf ? 6 : 11;
    int cap  = isf ? 5 : 10;
    for (int c = 0; c <= last; c++) begin
      bit e_oe = isw || (isf && c < 3) || (isr && c < 5);
      ad_in = (c == cap) ? rin : ~rin;
      chk(ale == (c < 2), "R2 ale", ale, c < 2);
      chk(ahi == a[15:8], "R2 ahi", ahi, a[15:8]);
      chk(psen_n == !(isf && c >= 3 && c <= 5), "R3 psen_n", psen_n, !(isf && c >= 3 && c <= 5));
      chk(rd_n == !(isr && c >= 5 && c <= 10), "R4 rd_n", rd_n, !(isr && c >= 5 && c <= 10));
      chk(wr_n == !(isw && c >= 5 && c <= 10), "R5 wr_n", wr_n, !(isw && c >= 5 && c <= 10));
      chk(oe == e_oe, "R7 ad_oe", oe, e_oe);
      if (e_oe && isw && c >= 4) chk(ad_out == d, "R6 wdata", ad_out, d);
      else if (e_oe)             chk(ad_out == a[7:0], "R2 addr_lo", ad_out, a[7:0]);
      chk(busy == (c < last), "R10 busy", busy, c < last);
      chk(done == (c == last), "R9 done", done, c == last);
      if (c == last && !isw) chk(rdata == rin, "R8 rdata", rdata, rin);
      if (ign && c == 3) begin req = 1'b1; kind = 2'd2; addr = 16'hFFFF; end
      if (ign && c == 8) req = 1'b0;
      if (hold && c == last) begin req = 1'b1; kind = nk; addr = na; wdata = nd; end
      @(negedge clk);
    end
    if (hold) req = 1'b0;
    else begin
      chk(!ale && !busy && !done && !oe, "R10 idle after cycle", {ale, busy, done, oe}, 0);
      if (!isw) chk(rdata == rin, "R8 rdata held", rdata, rin);
    end
  endtask

  task automatic t_reset;
    chk(!ale && psen_n && rd_n && wr_n && !oe && !busy && !done, "R1 reset",
        {ale, psen_n, rd_n, wr_n, oe, busy, done}, 7'b0111000);
  endtask

  task automatic t_fetch;
    launch(2'd0, 16'h12A5, 8'h00);
    run_body(2'd0, 16'h12A5, 8'h00, 8'h3C, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
  endtask

  task automatic t_read;
    launch(2'd1, 16'h8F01, 8'h00);
    run_body(2'd1, 16'h8F01, 8'h00, 8'hC7, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
    launch(2'd3, 16'h4466, 8'h00); // code 3 runs as read (R4)
    run_body(2'd3, 16'h4466, 8'h00, 8'h5A, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
  endtask

  task automatic t_write;
    launch(2'd2, 16'hBEEF, 8'h96);
    run_body(2'd2, 16'hBEEF, 8'h96, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
  endtask

  task automatic t_ignore;
    launch(2'd1, 16'h0A0B, 8'h00);
    run_body(2'd1, 16'h0A0B, 8'h00, 8'h81, 1'b1, 1'b0, 2'd0, 16'h0, 8'h0);
    @(negedge clk);
    chk(!ale && !busy, "R10 ignored request started nothing", {ale, busy}, 0);
  endtask

  task automatic t_chain;
    launch(2'd2, 16'h7001, 8'hE4);
    run_body(2'd2, 16'h7001, 8'hE4, 8'h00, 1'b0, 1'b1, 2'd0, 16'h3302, 8'h00);
    chk(ale == 1'b1, "R11 chained ale", ale, 1);
    run_body(2'd0, 16'h3302, 8'h00, 8'h19, 1'b0, 1'b1, 2'd1, 16'hC0DE, 8'h00);
    run_body(2'd1, 16'hC0DE, 8'h00, 8'hA2, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_read();
    t_write();
    t_ignore();
    t_chain();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule